// File: doc/BRIEF.md
# Fourth-Order Single-Bit Digital Noise-Shaping Requantizer

This block takes a stream of 12-level signed samples, such as the codes of a multi-bit analog modulator, and turns it into a one-bit stream at the same rate. It does this with a fully digital loop of four cascaded delaying accumulators. Each accumulator receives a shift-and-add weighted copy of the difference between the input and the fed-back bit. A small extra feedback from the fourth accumulator into the third moves one pair of noise zeros a little away from DC. The output bit is the sign of the last accumulator plus the current input. The loop is built so that the in-band signal passes with unity gain and the truncation error is pushed to high frequencies with fourth-order shaping.

The block has a valid/ready stream on each side. One input sample is taken per transfer, and each sample produces exactly one output bit. When the consumer deasserts `out_ready` while an output bit is pending, the block deasserts `in_ready`. The pending bit and the whole loop state then stay frozen until the bit is taken. A new sample is accepted in the same cycle in which the pending bit is consumed. Accumulators are sized with headroom so that no accumulator wraps for any legal input sequence.

Top module: `sdr_requant`

## Requirements
- R1: Synchronous reset clears all four accumulators, drives `out_valid` and `out_bit` to 0 and leaves `in_ready` at 1. The output stays 0 until the first sample is accepted.
- R2: `in_ready` is 1 exactly when no output bit is pending or `out_ready` is 1. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `out_valid` is 1 in the following cycle.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_bit` hold their values. An input presented while `in_ready` is 0 has no effect on any later output bit.
- R4: The input `in_code` is a two's-complement value from the odd set -11, -9, ..., +9, +11, which gives 12 levels. Internally it is scaled by 2^SCALE. For an accepted sample, the output bit is 1 when (fourth accumulator + scaled input) is at least 0, and 0 when it is negative.
- R5: The fed-back value is +FULL_SCALE·2^SCALE for bit 1 and -FULL_SCALE·2^SCALE for bit 0. The error term d is the scaled input minus the fed-back value.
- R6: On each accepted sample the accumulators update as follows:
  - a1 += d·2^-7
  - a2 += a1 + d·2^-4
  - a3 += a2 + d·(2^-2+2^-3) - a4·2^-9
  - a4 += a3 + d·(2^-1+2^-2)
  - All right-hand sides use the values before the update.
- R7: Every shift in R6 is an arithmetic right shift, which rounds toward minus infinity. This also applies to the -a4·2^-9 term: a4 is shifted first, then negated.
- R8: The loop state does not change in a cycle without an accepted sample.
- R9: For any sequence of legal input codes, no accumulator ever leaves its configured width. Each registered value equals the unwrapped sum.
- R10: For a constant input x, the mean of the output stream expressed as ±FULL_SCALE equals x within 1% of full scale over 1,500 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_code | input | IN_W | Signed 12-level input code |
| out_valid | output | 1 | Output bit pending |
| out_ready | input | 1 | Consumer takes the pending bit |
| out_bit | output | 1 | Single-bit output stream |

## Verification
The bench runs a reference model of the difference equations on wide integers and compares every output bit against it. The input mixes constant codes at both extremes and at small values, a full-scale sine, and random codes with random gaps and back-pressure.
- A wrong shift rounding, a swapped coefficient or a sign error on the zero-moving feedback makes the bitstream diverge from the model within a few hundred samples.
- A loop that steps during a stall, or that takes the input presented while not ready, also breaks bit-exactness. A bit that changes under back-pressure shows up as well.
- The DC density checks catch a loop whose signal gain is not unity.
- The model also checks that its accumulator values fit the configured widths, which catches widths chosen too narrow.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int NSTAGE = 4;
  // primary shift of each stage's error weight
  localparam int COEF_SH_A [NSTAGE] = '{7, 4, 2, 1};
  // secondary shift (0 = term absent)
  localparam int COEF_SH_B [NSTAGE] = '{0, 0, 3, 2};
  // stage receiving the zero-moving feedback, and its shift
  localparam int RES_STAGE = 2;
  localparam int RES_SH    = 9;
endpackage

// File: rtl/sdr_coef.sv
module sdr_coef #(
  parameter int CW   = 24,
  parameter int SH_A = 1,
  parameter int SH_B = 0
) (
  input  logic signed [CW-1:0] d,
  output logic signed [CW-1:0] p
);
  logic signed [CW-1:0] part_a, part_b;
  assign part_a = d >>> SH_A;
  if (SH_B > 0) begin : g_two
    assign part_b = d >>> SH_B;
  end else begin : g_one
    assign part_b = '0;
  end
  assign p = part_a + part_b;
endmodule

// File: rtl/sdr_acc.sv
module sdr_acc #(
  parameter int W  = 16,
  parameter int CW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [CW-1:0] t_chain,
  input  logic signed [CW-1:0] t_fwd,
  input  logic signed [CW-1:0] t_res,
  output logic signed [CW-1:0] q_ext,
  output logic signed [CW-1:0] nxt
);
  logic signed [W-1:0] q;

  assign q_ext = CW'(q);
  assign nxt   = q_ext + t_chain + t_fwd + t_res;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt[W-1:0];
  end
endmodule

// File: rtl/sdr_quant.sv
module sdr_quant #(
  parameter int CW = 24,
  parameter logic signed [CW-1:0] FS_S = 4096
) (
  input  logic signed [CW-1:0] acc,
  input  logic signed [CW-1:0] xs,
  output logic                 bit_o,
  output logic signed [CW-1:0] fb
);
  logic signed [CW-1:0] sum;
  assign sum   = acc + xs;
  assign bit_o = ~sum[CW-1];
  assign fb    = bit_o ? FS_S : -FS_S;
endmodule

// File: rtl/sdr_requant.sv
module sdr_requant
  import sdr_pkg::*;
#(
  parameter int IN_W       = 5,
  parameter int SCALE      = 7,
  parameter int FULL_SCALE = 32,
  parameter int W1         = 16,
  parameter int W2         = 18,
  parameter int W3         = 20,
  parameter int W4         = 22
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_code,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_bit
);
  localparam int CW = W4 + 2;
  localparam int WS [NSTAGE] = '{W1, W2, W3, W4};
  localparam logic signed [CW-1:0] FS_S = CW'(FULL_SCALE * (2 ** SCALE));

  logic                 step;
  logic                 q_bit;
  logic signed [CW-1:0] x_s, fb_s, diff;
  logic signed [CW-1:0] term  [NSTAGE];
  logic signed [CW-1:0] st_ext[NSTAGE];
  logic signed [CW-1:0] nxt   [NSTAGE];

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;
  assign x_s      = CW'(in_code) <<< SCALE;

  sdr_quant #(.CW(CW), .FS_S(FS_S)) u_quant (
    .acc  (st_ext[NSTAGE-1]),
    .xs   (x_s),
    .bit_o(q_bit),
    .fb   (fb_s)
  );

  assign diff = x_s - fb_s;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic signed [CW-1:0] chain_in, res_in;

    sdr_coef #(.CW(CW), .SH_A(COEF_SH_A[k]), .SH_B(COEF_SH_B[k])) u_coef (
      .d(diff),
      .p(term[k])
    );

    if (k == 0) begin : g_first
      assign chain_in = '0;
    end else begin : g_chain
      assign chain_in = st_ext[k-1];
    end

    if (k == RES_STAGE) begin : g_res
      assign res_in = -(st_ext[NSTAGE-1] >>> RES_SH);
    end else begin : g_nores
      assign res_in = '0;
    end

    sdr_acc #(.W(WS[k]), .CW(CW)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .en     (step),
      .t_chain(chain_in),
      .t_fwd  (term[k]),
      .t_res  (res_in),
      .q_ext  (st_ext[k]),
      .nxt    (nxt[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (step) begin
      out_valid <= 1'b1;
      out_bit   <= q_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_requant_chk.sv
module sdr_requant_chk #(
  parameter int W4 = 22
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_bit,
  input logic signed [W4+1:0]  st [4],
  input logic signed [W4+1:0]  nx [4]
);
  logic step;
  assign step = in_valid && in_ready;

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_bit));  // R1

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);  // R2

  AST_BP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));  // R3

  for (genvar k = 0; k < 4; k++) begin : g_st
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(st[k]));  // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      step |=> (st[k] == $past(nx[k])));  // R9
  end
endmodule

bind sdr_requant sdr_requant_chk #(.W4(W4)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bit  (out_bit),
  .st       (st_ext),
  .nx       (nxt)
);

// File: tb/test_sdr_requant.sv
`timescale 1ns/1ps
module test_sdr_requant;
  localparam int IN_W = 5, SCALE = 7, FS = 32;
  localparam int W1 = 16, W2 = 18, W3 = 20, W4 = 22;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic signed [IN_W-1:0] in_code = '0;
  logic in_ready, out_valid, out_bit;

  always #2.5 clk = ~clk;

  sdr_requant #(.IN_W(IN_W), .SCALE(SCALE), .FULL_SCALE(FS),
                .W1(W1), .W2(W2), .W3(W3), .W4(W4)) i_sdr_requant (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit));

  int nvec = 0, nfail = 0;
  bit done = 0;
  longint m1 = 0, m2 = 0, m3 = 0, m4 = 0;
  bit exp_valid = 0, exp_bit = 0;
  int dens_n = 0, dens_ones = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit fits(input longint v, input int w);
    longint lim = longint'(1) <<< (w - 1);
    return (v < lim) && (v >= -lim);
  endfunction

  // reference difference equations (R4-R7), evaluated on wide integers
  function automatic bit model_step(input int x);
    longint xs = longint'(x) * (longint'(1) <<< SCALE);
    longint fbv, d, n1, n2, n3, n4;
    bit b = ((m4 + xs) >= 0);
    fbv = b ? (longint'(FS) <<< SCALE) : -(longint'(FS) <<< SCALE);
    d  = xs - fbv;
    n1 = m1 + (d >>> 7);
    n2 = m2 + m1 + (d >>> 4);
    n3 = m3 + m2 + (d >>> 2) + (d >>> 3) - (m4 >>> 9);
    n4 = m4 + m3 + (d >>> 1) + (d >>> 2);
    m1 = n1; m2 = n2; m3 = n3; m4 = n4;
    return b;
  endfunction

  task automatic cyc(input bit iv, input int code, input bit ordy);
    bit acc, b, er;
    @(negedge clk);
    chk(out_valid == exp_valid, "R2/R3 out_valid", out_valid, exp_valid);
    if (exp_valid)
      chk(out_bit == exp_bit, "R4/R5/R6/R7 out_bit", out_bit, exp_bit);
    in_valid  = iv;
    in_code   = IN_W'(code);
    out_ready = ordy;
    #0.5;
    er = !exp_valid || ordy;
    chk(in_ready == er, "R2 in_ready", in_ready, er);
    acc = iv && er;
    if (acc) begin
      b = model_step(code);
      exp_valid = 1; exp_bit = b;
      dens_n++; dens_ones += b;
      if (!(fits(m1, W1) && fits(m2, W2) && fits(m3, W3) && fits(m4, W4)))
        chk(0, "R9 accumulator range", m4, 0);
    end else if (exp_valid && ordy) begin
      exp_valid = 0;
    end
  endtask

  task automatic dc_run(input int x, input int n);
    longint sum, tol;
    dens_n = 0; dens_ones = 0;
    for (int i = 0; i < n; i++) cyc(1, x, 1);
    // mean in units of FS: (2*ones - n)*FS should equal n*x within 1% of FS*n
    sum = longint'(2 * dens_ones - dens_n) * FS;
    tol = (longint'(dens_n) * FS) / 100;
    chk((sum - longint'(dens_n) * x <= tol) && (longint'(dens_n) * x - sum <= tol),
        "R10 DC density", sum, longint'(dens_n) * x);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(out_bit == 0, "R1 out_bit in reset", out_bit, 0);
    chk(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    rst = 0;
    // idle cycles: output must stay 0 until first sample (R1, R8)
    for (int i = 0; i < 4; i++) cyc(0, 11, 1);
    chk(out_bit == 0, "R1 out_bit before first sample", out_bit, 0);

    dc_run(11, 1500);
    dc_run(-11, 1500);
    dc_run(1, 1500);
    dc_run(-3, 1500);

    // back-pressure: pending bit frozen, input while not ready ignored (R3)
    cyc(1, 5, 0);
    for (int i = 0; i < 6; i++) cyc(1, (i % 2) ? 11 : -11, 0);
    cyc(1, 7, 1);

    // full-scale sine (R6, R9)
    for (int n = 0; n < 2048; n++) begin
      real v = 11.0 * $sin(2.0 * 3.14159265358979 * n / 61.0);
      int c = 2 * int'($floor(v / 2.0)) + 1;
      if (c > 11) c = 11;
      if (c < -11) c = -11;
      cyc(1, c, 1);
    end

    // random codes, random gaps and back-pressure (R2, R3, R8)
    for (int n = 0; n < 6000; n++)
      cyc(($urandom % 4) != 0, 2 * int'($urandom_range(0, 11)) - 11, ($urandom % 3) != 0);

    // drain
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule